// File: doc/BRIEF.md
# Quad-Channel Converter Serial Load Front End

This block is the digital side of a four-channel, 16-bit converter. A host writes one channel at a time over a three-wire serial port made of an active-low select, a serial clock and a data line. Each transfer is an 18-bit word. Its two leading bits choose the channel and the remaining sixteen bits are the code, most significant bit first. When the select line is released, the code is written into that channel's input register.

Behind the four input registers sit four output registers. The values in these output registers are the block's outputs, which feed the analog ladders. An active-low, level-sensitive load line copies all input registers into the output registers at once, so several channels can be changed together. When the load line is held low, every write goes straight through. An asynchronous preset and the system reset both force every register to zero-scale or to half-scale, as chosen by a mode pin. A serial output repeats the input stream with a fixed delay, so several blocks can share one port in a chain.

The serial pins are asynchronous to the block. They are sampled through a two-stage synchronizer on the fast system clock, and edges are found from the synchronized samples.

Top module: `quad_dac_serial_front`

## Requirements
- R1: A word is sent MSB first. Its first two bits are the channel address, and the next sixteen bits are the code from bit 15 down to bit 0. Address 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel k appears on `dac_codes[16k+15:16k]`.
- R2: The shift register takes one bit on each synchronized rising edge of `sclk`, and only while `cs_n` is low. Clock edges while `cs_n` is high leave the shift register and `sdo` unchanged.
- R3: On a rising edge of `cs_n`, the 18 most recently shifted bits form the word. Any earlier bits of a longer transfer are ignored. A shorter transfer uses the newest bits together with older bits still held in the 18 positions.
- R4: An input register changes only on a rising edge of `cs_n`, and only the addressed one changes. While `load_n` is high, the outputs keep their values.
- R5: While `load_n` is low, all four outputs follow their input registers. A rising edge of `load_n` changes nothing.
- R6: If `cs_n` rises while `load_n` is already low, the addressed output takes the new code in the same cycle as its input register.
- R7: While `preset_n` is low, every input and output register is forced at once, with no clock edge needed, to 0000h when `half_scale` is 0 or to 8000h when it is 1.
- R8: When `rst_n` is low at a clock edge, all input and output registers take the same preset value selected by `half_scale`, and the shift register clears to zero.
- R9: The bit sampled on the n-th counted `sclk` rise appears on `sdo` after the (n+18)-th counted rise.
- R10: A pin edge acts at the third rising edge of `clk` after it first appears on the pin.
- R11: The reset has priority over a load caused by `cs_n` or by the load line in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset (power-on preset) |
| preset_n | input | 1 | Asynchronous active-low preset of all code registers |
| half_scale | input | 1 | Preset value: 0 gives 0000h, 1 gives 8000h |
| cs_n | input | 1 | Serial select, active low; its rising edge writes the word |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in |
| load_n | input | 1 | Level-sensitive load line, active low |
| sdo | output | 1 | Serial data out for chaining |
| dac_codes | output | 64 | Four output register codes, channel A in the low bits |

## Verification
The hardest states to reach are the edge cases of an overlap. One is a write made while the load line is already low. Another is a reset that arrives in exactly the cycle in which a select edge would write. Because of the synchronizer, that cycle lies three system clocks after the pin moves. The bench reaches it by releasing `cs_n` and counting edges before it drops `rst_n`. Long and short transfers are also sent back to back, so the leftover bits in the 18 positions decide the address. A behavioural model compares the outputs and `sdo` on every clock.

// File: rtl/qdac_pkg.sv
// Package: shared types for the quad converter serial front end.
// Assumes: four serial pins sampled together as one bundle.
package qdac_pkg;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
        logic load_n;
    } pins_t;

    // Idle level of each pin, used as the synchronizer reset value.
    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0, load_n: 1'b1};

endpackage

// File: rtl/qdac_sync.sv
// Module: qdac_sync
// Brings the asynchronous serial pins into the clk domain through STAGES
// flops per pin. Assumes the pins change slowly compared with clk.
module qdac_sync
    import qdac_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_in,
    output pins_t pins_out
);

    pins_t stage_q [STAGES];

    // Purpose: shift the pin samples through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= PINS_IDLE;
        end else begin
            stage_q[0] <= pins_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign pins_out = stage_q[STAGES-1];

endmodule

// File: rtl/qdac_shifter.sv
// Module: qdac_shifter
// Serial shift chain of FRAME_W+1 bits. Finds edges on the synchronized
// select and clock, shifts on clock rises while selected, and raises
// word_valid for one cycle on the select rise. The top bit drives sdo.
// Assumes synchronized inputs.
module qdac_shifter #(
    parameter int FRAME_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               sdi_s,
    output logic [FRAME_W-1:0] word,
    output logic               word_valid,
    output logic               sdo
);

    localparam int CHAIN_W = FRAME_W + 1;

    logic               cs_d, sclk_d;
    logic               shift_en;
    logic [CHAIN_W-1:0] chain;

    assign shift_en   = sclk_s & ~sclk_d & ~cs_n_s;
    assign word_valid = cs_n_s & ~cs_d;

    // Purpose: remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_n_s;
            sclk_d <= sclk_s;
        end
    end

    // Purpose: advance the serial chain one bit per qualified clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        chain <= '0;
        else if (shift_en) chain <= {chain[CHAIN_W-2:0], sdi_s};
    end

    assign word = chain[FRAME_W-1:0];
    assign sdo  = chain[CHAIN_W-1];

    // R2: the chain moves only on a qualified shift.
    p_idle_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain));

    // R9: sdo takes the bit that sat just below the top before the shift.
    p_sdo_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sdo == $past(chain[CHAIN_W-2])));

endmodule

// File: rtl/qdac_bank.sv
// Module: qdac_bank
// Input and output code registers for CHANNELS channels. A write goes to
// the addressed input register. A low load level copies the updated input
// registers into the output registers. Assumes load_n is synchronized;
// preset_n acts asynchronously and rst_n synchronously.
module qdac_bank #(
    parameter int CHANNELS = 4,
    parameter int CODE_W   = 16,
    parameter int ADDR_W   = $clog2(CHANNELS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       preset_n,
    input  logic                       half_scale,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CODE_W-1:0]          wr_data,
    input  logic                       load_n,
    output logic [CHANNELS*CODE_W-1:0] dac_flat
);

    localparam logic [CODE_W-1:0] HALF_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0]          preset_code;
    logic [CODE_W-1:0]          input_q [CHANNELS];
    logic [CODE_W-1:0]          in_next [CHANNELS];
    logic [CODE_W-1:0]          dac_q   [CHANNELS];
    logic [CHANNELS*CODE_W-1:0] in_flat;

    assign preset_code = half_scale ? HALF_CODE : '0;

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        // Purpose: next input value, replaced only on a write to this channel.
        always_comb begin
            in_next[g] = input_q[g];
            if (wr_en && (wr_addr == ADDR_W'(g))) in_next[g] = wr_data;
        end

        // Purpose: hold the input and output codes with preset and reset priority.
        always_ff @(posedge clk or negedge preset_n) begin
            if (!preset_n) begin
                input_q[g] <= preset_code;
                dac_q[g]   <= preset_code;
            end else if (!rst_n) begin
                input_q[g] <= preset_code;
                dac_q[g]   <= preset_code;
            end else begin
                input_q[g] <= in_next[g];
                if (!load_n) dac_q[g] <= in_next[g];
            end
        end

        assign dac_flat[g*CODE_W +: CODE_W] = dac_q[g];
        assign in_flat[g*CODE_W +: CODE_W]  = input_q[g];

        // R8 and R11: a reset edge leaves the preset value, whatever was written.
        p_reset_preset_r8: assert property (@(posedge clk) disable iff (!preset_n)
            !rst_n |=> (dac_q[g] == ($past(half_scale) ? HALF_CODE : '0)));
    end

    // R5: with the load line low the outputs match the input registers.
    p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
        !load_n |=> (dac_flat == in_flat));

    // R4 and R5: with the load line high the outputs hold.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
        load_n |=> $stable(dac_flat));

endmodule

// File: rtl/quad_dac_serial_front.sv
// Module: quad_dac_serial_front
// Top of the quad converter serial front end: synchronizer, shift chain
// and register bank. Assumes CHANNELS is a power of two and clk runs
// several times faster than sclk.
module quad_dac_serial_front #(
    parameter int CHANNELS    = 4,
    parameter int CODE_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       preset_n,
    input  logic                       half_scale,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       sdi,
    input  logic                       load_n,
    output logic                       sdo,
    output logic [CHANNELS*CODE_W-1:0] dac_codes
);
    import qdac_pkg::*;

    localparam int ADDR_W  = $clog2(CHANNELS);
    localparam int FRAME_W = ADDR_W + CODE_W;

    pins_t              pins_raw, pins_s;
    logic [FRAME_W-1:0] word;
    logic               word_valid;

    assign pins_raw = '{cs_n: cs_n, sclk: sclk, sdi: sdi, load_n: load_n};

    qdac_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_in  (pins_raw),
        .pins_out (pins_s)
    );

    qdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (pins_s.cs_n),
        .sclk_s     (pins_s.sclk),
        .sdi_s      (pins_s.sdi),
        .word       (word),
        .word_valid (word_valid),
        .sdo        (sdo)
    );

    qdac_bank #(.CHANNELS(CHANNELS), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_n   (preset_n),
        .half_scale (half_scale),
        .wr_en      (word_valid),
        .wr_addr    (word[FRAME_W-1 -: ADDR_W]),
        .wr_data    (word[CODE_W-1:0]),
        .load_n     (pins_s.load_n),
        .dac_flat   (dac_codes)
    );

endmodule

// File: tb/quad_dac_serial_front_test.sv
module quad_dac_serial_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, preset_n = 1'b1, half_scale = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1;
    logic        sdo;
    logic [63:0] dac_codes;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    quad_dac_serial_front uut (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .half_scale(half_scale),
        .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .load_n(load_n),
        .sdo(sdo), .dac_codes(dac_codes)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_in [4];
    logic [15:0] m_dac [4];
    logic        mq [$];                          // newest bit at index 0
    logic        h_cs [4], h_ck [4], h_di [4], h_ld [4];  // pin history, 0 = newest

    function automatic logic [15:0] pv();
        return half_scale ? 16'h8000 : 16'h0000;
    endfunction

    task automatic m_preset();
        for (int c = 0; c < 4; c++) begin m_in[c] = pv(); m_dac[c] = pv(); end
    endtask

    always @(negedge preset_n) m_preset();

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                h_cs[i] = 1'b1; h_ck[i] = 1'b0; h_di[i] = 1'b0; h_ld[i] = 1'b1;
            end
            mq = {};
            for (int i = 0; i < 19; i++) mq.push_back(1'b0);
            m_preset();
        end else begin
            for (int i = 3; i > 0; i--) begin
                h_cs[i] = h_cs[i-1]; h_ck[i] = h_ck[i-1];
                h_di[i] = h_di[i-1]; h_ld[i] = h_ld[i-1];
            end
            h_cs[0] = cs_n; h_ck[0] = sclk; h_di[0] = sdi; h_ld[0] = load_n;
            if (h_ck[2] && !h_ck[3] && !h_cs[2]) begin
                mq.push_front(h_di[2]);
                void'(mq.pop_back());
            end
            if (!preset_n) m_preset();
            else begin
                if (h_cs[2] && !h_cs[3]) begin
                    int a;
                    logic [15:0] d;
                    a = {mq[17], mq[16]};
                    for (int b = 0; b < 16; b++) d[b] = mq[b];
                    m_in[a] = d;
                end
                if (!h_ld[2]) for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ch(int c);
        return dac_codes[c*16 +: 16];
    endfunction

    // Per-clock comparison against the model (R10 timing, R9 serial out).
    always @(negedge clk) begin
        #1;
        if (rst_n && mq.size() == 19) begin
            for (int c = 0; c < 4; c++) check($sformatf("R10 model ch%0d", c), ch(c), m_dac[c]);
            check("R9 model sdo", sdo, mq[18]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i]; sclk = 1'b0; tick(3);
            sclk = 1'b1; tick(3);
        end
        sclk = 1'b0; tick(3);
    endtask

    task automatic frame(logic [31:0] v, int n);
        cs_n = 1'b0; tick(3);
        bits(v, n);
        cs_n = 1'b1; tick(6);
    endtask

    task automatic pulse_load();
        load_n = 1'b0; tick(4);
        load_n = 1'b1; tick(4);
    endtask

    initial begin
        logic [17:0] w;
        logic        s0;
        tick(3);
        rst_n = 1'b1; tick(3);
        for (int c = 0; c < 4; c++) check("R8 reset zero", ch(c), 16'h0000);

        frame({2'b00, 16'h1234}, 18);
        check("R4 held while load high", ch(0), 16'h0000);
        pulse_load();
        check("R1 channel A", ch(0), 16'h1234);

        frame({2'b11, 16'hBEEF}, 18);
        frame({2'b10, 16'h0F0F}, 18);
        frame({2'b01, 16'h8001}, 18);
        pulse_load();
        check("R1 channel D", ch(3), 16'hBEEF);
        check("R1 channel C", ch(2), 16'h0F0F);
        check("R1 channel B", ch(1), 16'h8001);

        frame({2'b00, 16'h5555}, 18);
        check("R5 load rise no change", ch(0), 16'h1234);

        frame({4'hF, 2'b10, 16'hABCD}, 22);
        pulse_load();
        check("R3 long word", ch(2), 16'hABCD);
        check("R4 A loaded", ch(0), 16'h5555);

        frame(32'h3C, 8);
        pulse_load();
        w = {18'h2ABCD, 8'h3C} & 18'h3FFFF;
        check("R3 short word addr D", ch(3), w[15:0]);

        s0 = sdo;
        sdi = 1'b1;
        for (int i = 0; i < 10; i++) begin sclk = 1'b1; tick(3); sclk = 1'b0; tick(3); end
        check("R2 sdo unchanged while deselected", sdo, s0);
        frame(32'hA5, 8);
        pulse_load();
        w = {w[9:0], 8'hA5};
        check("R2 no stray bits, B", ch(1), w[15:0]);

        load_n = 1'b0; tick(4);
        cs_n = 1'b0; tick(3);
        bits({2'b01, 16'h7777}, 18);
        cs_n = 1'b1;
        tick(2);
        check("R10 not yet after two edges", ch(1), w[15:0]);
        tick(1);
        check("R6 through-load after third edge", ch(1), 16'h7777);
        tick(4);
        load_n = 1'b1; tick(4);

        cs_n = 1'b0; tick(3);
        bits(32'h40000, 19);
        check("R9 first bit on sdo", sdo, 1'b1);
        bits(32'h0, 1);
        check("R9 next bit on sdo", sdo, 1'b0);
        cs_n = 1'b1; tick(6);

        half_scale = 1'b1;
        preset_n = 1'b0;
        #1;
        for (int c = 0; c < 4; c++) check("R7 async half preset", ch(c), 16'h8000);
        tick(2);
        preset_n = 1'b1; tick(2);

        half_scale = 1'b0;
        load_n = 1'b0;
        cs_n = 1'b0; tick(3);
        bits({2'b00, 16'hFFFF}, 18);
        cs_n = 1'b1;
        tick(2);
        rst_n = 1'b0;
        tick(1);
        for (int c = 0; c < 4; c++) check("R11 reset beats write", ch(c), 16'h0000);
        rst_n = 1'b1; load_n = 1'b1; tick(6);
        check("R11 write dropped", ch(0), 16'h0000);

        half_scale = 1'b1;
        rst_n = 1'b0; tick(2);
        rst_n = 1'b1; tick(2);
        for (int c = 0; c < 4; c++) check("R8 reset half", ch(c), 16'h8000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule